// File: doc/BRIEF.md
# Transfer Word Down-Counter

This block keeps the number of words still owed in a block transfer. The host first writes a start count. Every word that leaves the data buffer then lowers that count by one. The host can clear the counter or read it back at any time over a parallel bus. Two level flags and a pulse report the count to the status and interrupt logic:

- a zero-status bit, which is low only when the count is zero;
- an end-of-transfer flag, which sets when the last word is taken;
- a single-clock terminal-count pulse, which also marks the last word.

All state sits in flops, so a command that is sampled on a clock edge is visible from just after that edge. When several commands arrive in the same cycle, the order is: a clear beats a load, and a load beats a decrement.

Top module: `xfer_countdown`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `count_q` is 0, `zero_n` is 0, `eot` is 0 and `tc_pulse` is 0.
- R2: A cycle with `load_en` high (and `cnt_clr` low) puts `load_val` into `count_q` after that edge. Every one of the 24 bit positions loads and reads back on its own: a single 1 walked from bit 0 to bit 23 reads back exactly each time.
- R3: A cycle with `cnt_clr` high puts 0 in `count_q` and clears `eot` and `tc_pulse`.
- R4: A cycle with `dec_en` high, no clear, no load and a non-zero count lowers `count_q` by exactly one. For example, starting from 64, taking 15, 32 and 16 words gives 49, 17 and 1.
- R5: `zero_n` is 1 whenever `count_q` is non-zero and 0 whenever `count_q` is zero.
- R6: `eot` rises on the decrement from 1 to 0. It stays high until a clear, a load or a reset.
- R7: A decrement request while the count is 0 is ignored. `count_q` stays 0 (it never wraps to all ones), `eot` keeps its value and `tc_pulse` stays low.
- R8: `tc_pulse` is high for exactly one clock after the decrement from 1 to 0. A load or a clear never produces it, and that includes a load of 0.
- R9: Commands in the same cycle follow a fixed order: clear, then load, then decrement. Clear together with load gives 0. Load together with decrement gives the loaded value, not one less.
- R10: A load clears `eot`, whatever value is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr | input | 1 | Host clear of the counter |
| load_en | input | 1 | Load strobe |
| load_val | input | WIDTH (24) | Value written by a load |
| dec_en | input | 1 | One word taken from the buffer |
| count_q | output | WIDTH (24) | Current count, for host readback |
| zero_n | output | 1 | Low when the count is zero |
| eot | output | 1 | End-of-transfer flag |
| tc_pulse | output | 1 | One-clock terminal-count pulse |

## Verification
The bench walks a single 1 through all 24 bit positions. A bit that is stuck or shorted in the load or readback path then shows up as a wrong readback. It runs the 64 → 49 → 17 → 1 → 0 sequence and watches the flags at one word left and at zero. A design with the zero-status polarity inverted, or with the end-of-transfer flag set one word early, fails there. It decrements again at zero to catch a counter that wraps to all ones or pulses again. It also loads 0 and issues a clear to expose a terminal pulse wrongly raised by a non-decrement path. Finally, it issues commands in the same cycle to catch a wrong priority between clear, load and decrement.

// File: rtl/xfer_countdown.sv
module xfer_countdown #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec_en,
  output logic [WIDTH-1:0] count_q,
  output logic             zero_n,
  output logic             eot,
  output logic             tc_pulse
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_r;
  logic             eot_r;
  logic             tc_r;

  wire at_zero = (cnt_r == '0);
  wire at_one  = (cnt_r == ONE);
  wire do_dec  = dec_en && !at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
      eot_r <= 1'b0;
      tc_r  <= 1'b0;
    end else if (cnt_clr) begin
      cnt_r <= '0;
      eot_r <= 1'b0;
      tc_r  <= 1'b0;
    end else if (load_en) begin
      cnt_r <= load_val;
      eot_r <= 1'b0;
      tc_r  <= 1'b0;
    end else if (do_dec) begin
      cnt_r <= cnt_r - ONE;
      eot_r <= eot_r | at_one;
      tc_r  <= at_one;
    end else begin
      tc_r  <= 1'b0;
    end
  end

  assign count_q  = cnt_r;
  assign zero_n   = !at_zero;
  assign eot      = eot_r;
  assign tc_pulse = tc_r;

endmodule

// File: rtl/xfer_countdown_chk.sv
module xfer_countdown_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clr,
  input logic             load_en,
  input logic [WIDTH-1:0] load_val,
  input logic             dec_en,
  input logic [WIDTH-1:0] count_q,
  input logic             zero_n,
  input logic             eot,
  input logic             tc_pulse
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !cnt_clr) |=> (count_q == $past(load_val)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count_q == '0 && !eot && !tc_pulse));

  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !cnt_clr && !load_en && count_q != '0)
      |=> (count_q == $past(count_q) - WIDTH'(1)));

  p_eot_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> !zero_n);

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !cnt_clr && !load_en && count_q == '0)
      |=> (count_q == '0 && !tc_pulse));

  p_tc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  p_tc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (count_q == '0 && eot && $past(count_q) == WIDTH'(1)));

  p_load_clears_eot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !cnt_clr) |=> (!eot && !tc_pulse));

endmodule

bind xfer_countdown xfer_countdown_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .load_en(load_en),
  .load_val(load_val), .dec_en(dec_en), .count_q(count_q),
  .zero_n(zero_n), .eot(eot), .tc_pulse(tc_pulse)
);

// File: tb/sim_xfer_countdown.sv
`timescale 1ns/1ps
module sim_xfer_countdown;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_clr = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         dec_en = 1'b0;
  logic [W-1:0] count_q;
  logic         zero_n, eot, tc_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  xfer_countdown #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .load_en(load_en),
    .load_val(load_val), .dec_en(dec_en), .count_q(count_q),
    .zero_n(zero_n), .eot(eot), .tc_pulse(tc_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [W-1:0] c,
                         input logic z, input logic e, input logic t);
    chk({tag, " count"}, 32'(count_q), 32'(c));
    chk({tag, " zero_n"}, 32'(zero_n), 32'(z));
    chk({tag, " eot"}, 32'(eot), 32'(e));
    chk({tag, " tc"}, 32'(tc_pulse), 32'(t));
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_en = 1'b1; load_val = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_dec(input int n);
    dec_en = 1'b1;
    repeat (n) @(negedge clk);
    dec_en = 1'b0;
  endtask

  task automatic t_reset;
    chk_all("R1 in reset", '0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_walk;
    for (int i = 0; i < W; i++) begin
      do_load(W'(1) << i);
      chk("R2 walking one", 32'(count_q), 32'(W'(1) << i));
      chk("R5 zero_n nonzero", 32'(zero_n), 32'd1);
    end
    do_load('1);
    chk("R2 all ones", 32'(count_q), 32'hFFFFFF);
  endtask

  task automatic t_countdown;
    do_load(W'(64));
    chk("R2 load 64", 32'(count_q), 32'd64);
    do_dec(15); chk("R4 after 15", 32'(count_q), 32'd49);
    do_dec(32); chk("R4 after 32", 32'(count_q), 32'd17);
    do_dec(16);
    chk_all("R5 R6 one left", W'(1), 1'b1, 1'b0, 1'b0);
    do_dec(1);
    chk_all("R6 R8 terminal", '0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk_all("R8 pulse ended", '0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_underflow;
    do_dec(3);
    chk_all("R7 dec at zero", '0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_clear;
    do_load(W'(5));
    chk("R10 load clears eot", 32'(eot), 32'd0);
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    chk_all("R3 clear", '0, 1'b0, 1'b0, 1'b0);
    do_load(W'(1)); do_dec(1);
    chk("R6 set again", 32'(eot), 32'd1);
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    chk_all("R3 clear eot", '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_load_zero;
    do_load(W'(1)); do_dec(1);
    do_load('0);
    chk_all("R8 R10 load zero", '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    do_load(W'(9));
    cnt_clr = 1'b1; load_en = 1'b1; load_val = W'(33);
    @(negedge clk);
    cnt_clr = 1'b0; load_en = 1'b0;
    chk("R9 clear beats load", 32'(count_q), 32'd0);
    load_en = 1'b1; dec_en = 1'b1; load_val = W'(33);
    @(negedge clk);
    load_en = 1'b0; dec_en = 1'b0;
    chk("R9 load beats dec", 32'(count_q), 32'd33);
    do_load(W'(1));
    cnt_clr = 1'b1; dec_en = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0; dec_en = 1'b0;
    chk_all("R9 clear beats dec", '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_walk();
    t_countdown();
    t_underflow();
    t_clear();
    t_load_zero();
    t_priority();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule